// File: doc/BRIEF.md
# SPI Slave Peripheral with Guarded Receive Buffer

This block is an 8-bit SPI slave that sits on a small byte-wide register bus of a microcontroller. Software places a byte in a transmit buffer. An external master clocks that byte out on MISO while it shifts a byte in on MOSI. The block works in SPI mode 0 only, and every byte moves most significant bit first. SCK, the active-low select and MOSI are brought into the system clock domain through two-flop synchronisers. All shifting is then done with edge strobes derived in that clock domain.

Reception is under software control. A receive-enable bit must be armed before any completed byte is kept. A delivered byte raises a receive flag and a data-ready bit. The receive buffer is then protected until software clears data-ready. A byte that completes while data-ready is still set is dropped, and a sticky overrun bit records the loss. The MISO driver is enabled only while the select input is active. One interrupt line combines the receive flag, gated by an enable bit, with a transmit-empty indication.

Top module: `spi_guard_slave`

## Requirements
- R1: After reset, the transmit buffer (address F3h), the receive buffer (address F4h) and the control/status byte (address F2h) all read 00h, and misoOe is 0.
- R2: misoOe is 1 exactly while ssNIn is low. While ssNIn is high, MISO must be treated as high-impedance.
- R3: While the receive-enable bit (bit 0 of F2h) is 1 and data-ready is 0, a byte shifted in on MOSI appears at F4h. The byte is sampled on rising SCK edges, MSB first.
- R4: MISO presents the byte the shifter took, MSB first, changing after each falling SCK edge. If the transmit buffer was empty when the shifter loaded, the byte sent is 00h.
- R5: Writing F3h sets the transmit-busy bit (bit 5 of F2h). The bit clears when the shifter takes the byte, either when select goes active or at the falling edge that ends the previous byte.
- R6: A kept byte sets the receive flag (bit 2) and data-ready (bit 3). Writing 1 to bit 2 clears the receive flag.
- R7: Data-ready is cleared only by writing 0 to bit 3; writing 1 to bit 3 has no effect. A byte that completes while data-ready is 1 leaves F4h unchanged and sets overrun (bit 4). Overrun is cleared by writing 1 to bit 4.
- R8: While the receive-enable bit is 0, completed bytes leave F4h and bits 2 to 4 unchanged.
- R9: irqOut equals (receive flag AND interrupt-enable bit 1) OR NOT transmit-busy.
- R10: Within one select-active frame, each following byte sends the byte written to F3h during the previous byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register address |
| busWrEn | input | 1 | Write strobe for one clock |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr (combinational) |
| sckIn | input | 1 | SPI serial clock from the master |
| ssNIn | input | 1 | Active-low slave select |
| mosiIn | input | 1 | Serial data in |
| misoOut | output | 1 | Serial data out |
| misoOe | output | 1 | Output enable for the MISO pad |
| irqOut | output | 1 | Interrupt request |

## Verification
The assertions assume four things about the inputs: SCK idles low and is stable while select changes, MOSI is stable around each rising SCK edge, and each SCK phase lasts several system clocks so that the synchronisers see every edge. The bench meets these assumptions. It holds each SCK phase for eight system clocks and changes MOSI only just after a falling edge. It moves select only while SCK is low, and it leaves idle gaps between frames. Bus writes last one clock, and reads are sampled mid-cycle.

// File: rtl/spi_guard_pkg.sv
package spi_guard_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic writeTx;
    logic loadShift;
    logic useZero;
    logic shiftOut;
    logic shiftIn;
    logic captureRx;
  } dpStrobes_t;
endpackage

// File: rtl/spi_guard_ctrl.sv
module spi_guard_ctrl
  import spi_guard_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] CTRL_ADDR = 8'hF2,
  parameter logic [7:0] TX_ADDR = 8'hF3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sckIn,
  input  logic        ssNIn,
  input  logic        mosiIn,
  input  logic [7:0]  busAddr,
  input  logic        busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output dpStrobes_t  strb,
  output logic        mosiBit,
  output logic [7:0]  statusByte,
  output logic        irqOut,
  output logic        misoOe
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] sckPipe, ssPipe, mosiPipe;
  logic sckPrev, ssPrev;
  logic sckS, ssActive, ssWasActive;
  logic sckRise, sckFall, frameStart, byteDone;
  logic [CNT_W-1:0] bitCnt;
  logic rxStart, irqEn, rxFlag, rxReady, overrun, txBusy;
  logic ctrlWr, txWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPipe  <= '0;
      ssPipe   <= '1;
      mosiPipe <= '0;
      sckPrev  <= 1'b0;
      ssPrev   <= 1'b1;
    end else begin
      sckPipe  <= {sckPipe[SYNC_STAGES-2:0], sckIn};
      ssPipe   <= {ssPipe[SYNC_STAGES-2:0], ssNIn};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosiIn};
      sckPrev  <= sckPipe[SYNC_STAGES-1];
      ssPrev   <= ssPipe[SYNC_STAGES-1];
    end
  end

  assign sckS        = sckPipe[SYNC_STAGES-1];
  assign ssActive    = !ssPipe[SYNC_STAGES-1];
  assign ssWasActive = !ssPrev;
  assign mosiBit     = mosiPipe[SYNC_STAGES-1];
  assign sckRise     = ssActive && sckS && !sckPrev;
  assign sckFall     = ssActive && !sckS && sckPrev;
  assign frameStart  = ssActive && !ssWasActive;
  assign byteDone    = sckRise && (bitCnt == LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          bitCnt <= '0;
    else if (!ssActive) bitCnt <= '0;
    else if (sckRise)   bitCnt <= bitCnt + 1'b1;
  end

  assign ctrlWr = busWrEn && (busAddr == CTRL_ADDR);
  assign txWr   = busWrEn && (busAddr == TX_ADDR);

  always_comb begin
    strb.writeTx   = txWr;
    strb.loadShift = frameStart || (sckFall && bitCnt == '0);
    strb.useZero   = !txBusy;
    strb.shiftOut  = sckFall && bitCnt != '0;
    strb.shiftIn   = sckRise;
    strb.captureRx = byteDone && rxStart && !rxReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxStart <= 1'b0;
      irqEn   <= 1'b0;
      rxFlag  <= 1'b0;
      rxReady <= 1'b0;
      overrun <= 1'b0;
      txBusy  <= 1'b0;
    end else begin
      if (ctrlWr) begin
        rxStart <= busWrData[0];
        irqEn   <= busWrData[1];
        if (busWrData[2])  rxFlag  <= 1'b0;
        if (!busWrData[3]) rxReady <= 1'b0;
        if (busWrData[4])  overrun <= 1'b0;
      end
      if (strb.captureRx) begin
        rxFlag  <= 1'b1;
        rxReady <= 1'b1;
      end
      if (byteDone && rxStart && rxReady) overrun <= 1'b1;
      if (strb.loadShift) txBusy <= 1'b0;
      if (txWr) txBusy <= 1'b1;
    end
  end

  assign statusByte = {2'b00, txBusy, overrun, rxReady, rxFlag, irqEn, rxStart};
  assign irqOut     = (rxFlag && irqEn) || !txBusy;
  assign misoOe     = !ssNIn;

  // R7
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && !ctrlWr) |=> rxReady);
  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && rxStart && !rxReady) |=> (rxFlag && rxReady));
  // R8
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rxStart && !ctrlWr) |=> ($stable(rxFlag) && $stable(overrun) && $stable(rxReady)));
  // R5
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadShift && !txWr) |=> !txBusy);
endmodule

// File: rtl/spi_guard_dp.sv
module spi_guard_dp
  import spi_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobes_t  strb,
  input  logic        mosiBit,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] txBufOut,
  output logic [DATA_W-1:0] rxBufOut,
  output logic        misoOut
);
  logic [DATA_W-1:0] txBuf, rxBuf, txShift, rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf   <= '0;
      rxBuf   <= '0;
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strb.writeTx) txBuf <= busWrData;
      if (strb.loadShift)     txShift <= strb.useZero ? '0 : txBuf;
      else if (strb.shiftOut) txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (strb.shiftIn)   rxShift <= {rxShift[DATA_W-2:0], mosiBit};
      if (strb.captureRx) rxBuf   <= {rxShift[DATA_W-2:0], mosiBit};
    end
  end

  assign txBufOut = txBuf;
  assign rxBufOut = rxBuf;
  assign misoOut  = txShift[DATA_W-1];

  // R7
  rx_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.captureRx |=> $stable(rxBuf));
  // R4
  empty_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadShift && strb.useZero) |=> (txShift == '0));
endmodule

// File: rtl/spi_guard_slave.sv
module spi_guard_slave
  import spi_guard_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] CTRL_ADDR = 8'hF2,
  parameter logic [7:0] TX_ADDR = 8'hF3,
  parameter logic [7:0] RX_ADDR = 8'hF4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] busAddr,
  input  logic       busWrEn,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  input  logic       sckIn,
  input  logic       ssNIn,
  input  logic       mosiIn,
  output logic       misoOut,
  output logic       misoOe,
  output logic       irqOut
);
  dpStrobes_t strb;
  logic mosiBit;
  logic [7:0] statusByte, txBufOut, rxBufOut;

  spi_guard_ctrl #(.SYNC_STAGES(SYNC_STAGES), .CTRL_ADDR(CTRL_ADDR), .TX_ADDR(TX_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .ssNIn(ssNIn), .mosiIn(mosiIn),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .strb(strb), .mosiBit(mosiBit), .statusByte(statusByte),
    .irqOut(irqOut), .misoOe(misoOe)
  );

  spi_guard_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mosiBit(mosiBit), .busWrData(busWrData),
    .txBufOut(txBufOut), .rxBufOut(rxBufOut), .misoOut(misoOut)
  );

  always_comb begin
    if (busAddr == CTRL_ADDR)    busRdData = statusByte;
    else if (busAddr == TX_ADDR) busRdData = txBufOut;
    else if (busAddr == RX_ADDR) busRdData = rxBufOut;
    else                         busRdData = '0;
  end
endmodule

// File: tb/spi_guard_slave_bench.sv
module spi_guard_slave_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic [7:0] busAddr = 8'h00, busWrData = 8'h00, busRdData;
  logic busWrEn = 1'b0, sckIn = 1'b0, ssNIn = 1'b1, mosiIn = 1'b0;
  logic misoOut, misoOe, irqOut;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_guard_slave u_spi_guard_slave (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .sckIn(sckIn), .ssNIn(ssNIn),
    .mosiIn(mosiIn), .misoOut(misoOut), .misoOe(misoOe), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic spiByte(input logic [7:0] txb, output logic [7:0] rxb);
    for (int i = 7; i >= 0; i--) begin
      mosiIn = txb[i];
      repeat (8) @(negedge clk);
      rxb[i] = misoOut;
      sckIn = 1'b1;
      repeat (8) @(negedge clk);
      sckIn = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic selectOn();
    @(negedge clk); ssNIn = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic selectOff();
    @(negedge clk); ssNIn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, m, t;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    busRead(8'hF3, r); chk("R1 tx", r, 8'h00);
    busRead(8'hF4, r); chk("R1 rx", r, 8'h00);
    busRead(8'hF2, r); chk("R1 status", r, 8'h00);
    chk("R1 oe", {7'b0, misoOe}, 8'h00);
    chk("R9 idle irq", {7'b0, irqOut}, 8'h01);
    // R2 output enable follows select
    ssNIn = 1'b0; #1 chk("R2 oe on", {7'b0, misoOe}, 8'h01);
    ssNIn = 1'b1; #1 chk("R2 oe off", {7'b0, misoOe}, 8'h00);
    busWrite(8'hF2, 8'h0B);
    busRead(8'hF2, r); chk("R7 write1 ready", r, 8'h03);
    // R4 empty buffer sends zero; R3 receive
    selectOn(); spiByte(8'hA5, m); selectOff();
    chk("R4 empty", m, 8'h00);
    busRead(8'hF4, r); chk("R3 rx", r, 8'hA5);
    busWrite(8'hF2, 8'h07);
    // sweep all byte values
    for (int v = 0; v < 256; v++) begin
      t = 8'(v * 7 + 3);
      busWrite(8'hF3, t);
      busRead(8'hF2, r); chk("R5 busy set", r, 8'h23);
      selectOn();
      busRead(8'hF2, r); chk("R5 busy clear", r, 8'h03);
      spiByte(8'(v), m); selectOff();
      chk("R4 miso", m, t);
      busRead(8'hF4, r); chk("R3 rx", r, 8'(v));
      busRead(8'hF2, r); chk("R6 flags", r, 8'h0F);
      busWrite(8'hF2, 8'h07);
      busRead(8'hF2, r); chk("R6 cleared", r, 8'h03);
    end
    // R9 interrupt combination
    selectOn(); spiByte(8'h5E, m); selectOff();
    busWrite(8'hF3, 8'h3C);
    @(negedge clk); chk("R9 flag en", {7'b0, irqOut}, 8'h01);
    busWrite(8'hF2, 8'h09);
    @(negedge clk); chk("R9 en off", {7'b0, irqOut}, 8'h00);
    busWrite(8'hF2, 8'h0B);
    @(negedge clk); chk("R9 en on", {7'b0, irqOut}, 8'h01);
    busWrite(8'hF2, 8'h0F);
    @(negedge clk); chk("R9 flag cleared", {7'b0, irqOut}, 8'h00);
    busRead(8'hF2, r); chk("R6 w1c", r, 8'h2B);
    busWrite(8'hF2, 8'h07);
    // R10 back-to-back, R7 overrun
    selectOn();
    busWrite(8'hF3, 8'hC3);
    spiByte(8'h11, m); chk("R10 first", m, 8'h3C);
    spiByte(8'h22, m); chk("R10 second", m, 8'hC3);
    selectOff();
    busRead(8'hF4, r); chk("R7 rx kept", r, 8'h11);
    busRead(8'hF2, r); chk("R7 overrun", r, 8'h1F);
    busWrite(8'hF2, 8'h17);
    busRead(8'hF2, r); chk("R7 overrun clear", r, 8'h03);
    // R8 disarmed
    busWrite(8'hF2, 8'h02);
    selectOn(); spiByte(8'h99, m); selectOff();
    busRead(8'hF4, r); chk("R8 rx unchanged", r, 8'h11);
    busRead(8'hF2, r); chk("R8 flags", r, 8'h02);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule